// File: doc/BRIEF.md
# SCSI DMA Channel Register Engine

This block is the DMA control and status register file of a bus-mastering SCSI host adapter. Eight 32-bit registers hold the channel command, the programmed (start) count, address and descriptor address, the running (working) count, address and descriptor address, and a status byte. Software programs the start registers and then issues a start command. The start copies the programmed values into the working registers, clears the status byte and enables the channel.

The DMA mover drives a small progress interface. Each request carries a length and a direction. The block answers in the same cycle with the granted length, which is the request clipped to the remaining working count. On the next edge it advances the working address and reduces the working count by the grant. Status reports completion, and a done interrupt is raised when it is enabled. One external mode input chooses how the completion-type status bits are cleared: either software writes ones to them, or a status read clears them. The interrupt flag of the SCSI core is merged into the status value as it is read, and is not stored.

Top module: `scsi_dma_regs`

## Requirements
- R1: After the synchronous reset, command, start count, start address, start descriptor, working count and status read 0, the working address reads 0xFFFFFFFF, the working descriptor reads 0xFFFFFFFD, and `dma_enable`, `cancel_req` and `done_irq` are low.
- R2: The register indices are 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor and 7 working descriptor. Writes to indices 0, 1, 2 and 6 are stored and read back on `rd_data`. Writes to indices 3, 4 and 7 change nothing.
- R3: Bits [1:0] of a command write select the operation. Code 0 (idle) drops `dma_enable` on the next cycle. Code 1 (blast) only stores the command. Code 2 (abort) raises `cancel_req` for exactly the next cycle. Code 3 (start) raises `dma_enable`.
- R4: A start command loads the working count, working address and working descriptor from their start registers and clears status bits [5:0].
- R5: Command bit 7 sets the direction: 1 means device to memory (`xfer_to_mem`=1), and 0 means memory to device. A request whose direction does not match gets a grant of 0 and changes no register.
- R6: A matching request is granted min(`xfer_len`, working count) in the same cycle. On the next edge the working count drops by the grant and the working address rises by it.
- R7: When a matching request leaves the working count at zero, status bit 3 (done) is set.
- R8: With `stat_wr1c_mode`=1, a status write clears each of bits 1 (error), 2 (abort) and 3 (done) that is written as 1. A status read clears nothing.
- R9: With `stat_wr1c_mode`=0, a status write has no effect. A status read with `rd_en` returns the value and then clears bits 1, 2 and 3 on that edge.
- R10: Status bit 4 on `rd_data` follows `core_irq` combinationally, whatever the stored state.
- R11: A `core_cmd_done` pulse sets the working count to 0 and sets done.
- R12: `done_irq` is high exactly when command bit 6 and status done are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index written |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (side effects only) |
| rd_idx | input | 3 | Register index shown on rd_data |
| rd_data | output | 32 | Combinational read data |
| stat_wr1c_mode | input | 1 | 1: write-one-to-clear status; 0: clear-on-read |
| core_irq | input | 1 | Interrupt flag from the SCSI core |
| core_cmd_done | input | 1 | Command-completion pulse from the SCSI core |
| xfer_req | input | 1 | Transfer step request |
| xfer_to_mem | input | 1 | Step direction, 1 = device to memory |
| xfer_len | input | 32 | Requested step length |
| xfer_grant | output | 32 | Granted step length, 0 if not accepted |
| dma_enable | output | 1 | Channel enabled |
| cancel_req | output | 1 | One-cycle request to cancel the current SCSI command |
| done_irq | output | 1 | Done interrupt |

## Verification
The clocked properties that check a register's next value assume that each cycle carries at most one of a register write, a status read with `rd_en`, a transfer request and a completion pulse, because the block defines no merged result for overlapping events. The bench drives exactly one such action per cycle through its driver tasks, even in the randomized phase, and it changes `core_irq` and the clear mode only on cycles that have no action. Reads for observation are made with `rd_en` low, so they have no side effect.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int IDX_W = 3;
    localparam int NREGS = 1 << IDX_W;

    // register indices: fixed by the programming model
    localparam logic [IDX_W-1:0] IDX_CMD  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_SCNT = 3'd1;
    localparam logic [IDX_W-1:0] IDX_SADR = 3'd2;
    localparam logic [IDX_W-1:0] IDX_WCNT = 3'd3;
    localparam logic [IDX_W-1:0] IDX_WADR = 3'd4;
    localparam logic [IDX_W-1:0] IDX_STAT = 3'd5;
    localparam logic [IDX_W-1:0] IDX_SDSC = 3'd6;
    localparam logic [IDX_W-1:0] IDX_WDSC = 3'd7;

    // command field positions
    localparam int CMD_DIR_BIT    = 7;
    localparam int CMD_DONE_IE    = 6;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_BLAST = 2'd1,
        OP_ABORT = 2'd2,
        OP_START = 2'd3
    } dmac_op_e;

    // status byte, msb first: bit5 .. bit0
    typedef struct packed {
        logic blast;
        logic sint;
        logic done;
        logic abort;
        logic err;
        logic pwdn;
    } dmac_stat_t;

    localparam int STAT_W = $bits(dmac_stat_t);
    localparam logic [STAT_W-1:0] STAT_CLR_MASK = 6'b00_1110;
    localparam logic [STAT_W-1:0] STAT_SINT     = 6'b01_0000;

    function automatic dmac_op_e decode_op(input logic [1:0] f);
        return dmac_op_e'(f);
    endfunction

endpackage

// File: rtl/dmac_cmd_ctrl.sv
module dmac_cmd_ctrl
    import dmac_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_wr,
    input  dmac_op_e op,
    output logic     start,
    output logic     dma_enable,
    output logic     cancel_req
);

    assign start = cmd_wr && (op == OP_START);

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_enable <= 1'b0;
            cancel_req <= 1'b0;
        end else begin
            cancel_req <= cmd_wr && (op == OP_ABORT);
            if (cmd_wr) begin
                case (op)
                    OP_IDLE:  dma_enable <= 1'b0;
                    OP_START: dma_enable <= 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    // R3
    abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cancel_req |=> !cancel_req || $past(cmd_wr && op == OP_ABORT));

    // R3
    idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && op == OP_IDLE) |=> !dma_enable);

    // R3
    blast_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && op == OP_BLAST) |=> $stable(dma_enable));

endmodule

// File: rtl/dmac_xfer_step.sv
module dmac_xfer_step #(
    parameter int DATA_W = 32
) (
    input  logic              req,
    input  logic              to_mem,
    input  logic              cmd_dir,
    input  logic [DATA_W-1:0] len,
    input  logic [DATA_W-1:0] wcnt,
    output logic              accept,
    output logic [DATA_W-1:0] grant,
    output logic [DATA_W-1:0] next_wcnt,
    output logic              reaches_zero
);

    logic [DATA_W-1:0] clipped;

    always_comb begin
        accept       = req && (to_mem == cmd_dir);
        clipped      = (len < wcnt) ? len : wcnt;
        grant        = accept ? clipped : '0;
        next_wcnt    = wcnt - grant;
        reaches_zero = (next_wcnt == '0);
    end

endmodule

// File: rtl/dmac_status_bits.sv
module dmac_status_bits
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_clr,
    input  logic              rd_clr,
    input  logic              w1c_en,
    input  logic [STAT_W-1:0] w1c_bits,
    input  logic              set_done,
    output dmac_stat_t        stat
);

    logic [STAT_W-1:0] nxt;

    always_comb begin
        nxt = stat;
        if (start_clr) nxt = '0;
        if (rd_clr)    nxt = nxt & ~STAT_CLR_MASK;
        if (w1c_en)    nxt = nxt & ~(w1c_bits & STAT_CLR_MASK);
        if (set_done)  nxt[3] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= dmac_stat_t'(nxt);
    end

    // R7
    done_sets_chk: assert property (@(posedge clk) disable iff (rst)
        set_done |=> stat.done);

    // R4
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (start_clr && !set_done) |=> (stat == '0));

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !set_done) |=> (!stat.done && !stat.abort && !stat.err));

endmodule

// File: rtl/scsi_dma_regs.sv
module scsi_dma_regs
    import dmac_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] WADR_INIT  = '1,
    parameter logic [DATA_W-1:0] WDSC_INIT  = 32'hFFFF_FFFD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              stat_wr1c_mode,
    input  logic              core_irq,
    input  logic              core_cmd_done,
    input  logic              xfer_req,
    input  logic              xfer_to_mem,
    input  logic [DATA_W-1:0] xfer_len,
    output logic [DATA_W-1:0] xfer_grant,
    output logic              dma_enable,
    output logic              cancel_req,
    output logic              done_irq
);

    logic [DATA_W-1:0] cmd_q, scnt_q, sadr_q, sdsc_q;
    logic [DATA_W-1:0] wcnt_q, wadr_q, wdsc_q;
    dmac_stat_t        stat_q;

    logic              cmd_wr, stat_wr, start, rd_clr, w1c_en;
    logic              x_accept, x_zero, set_done;
    logic [DATA_W-1:0] x_next;
    logic [STAT_W-1:0] stat_view;

    assign cmd_wr  = wr_en && (wr_idx == IDX_CMD);
    assign stat_wr = wr_en && (wr_idx == IDX_STAT);
    assign rd_clr  = rd_en && (rd_idx == IDX_STAT) && !stat_wr1c_mode;
    assign w1c_en  = stat_wr && stat_wr1c_mode;

    dmac_cmd_ctrl u_cmd (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr),
        .op         (decode_op(wr_data[1:0])),
        .start      (start),
        .dma_enable (dma_enable),
        .cancel_req (cancel_req)
    );

    dmac_xfer_step #(.DATA_W(DATA_W)) u_step (
        .req          (xfer_req),
        .to_mem       (xfer_to_mem),
        .cmd_dir      (cmd_q[CMD_DIR_BIT]),
        .len          (xfer_len),
        .wcnt         (wcnt_q),
        .accept       (x_accept),
        .grant        (xfer_grant),
        .next_wcnt    (x_next),
        .reaches_zero (x_zero)
    );

    assign set_done = core_cmd_done || (x_accept && x_zero);

    dmac_status_bits u_stat (
        .clk       (clk),
        .rst       (rst),
        .start_clr (start),
        .rd_clr    (rd_clr),
        .w1c_en    (w1c_en),
        .w1c_bits  (wr_data[STAT_W-1:0]),
        .set_done  (set_done),
        .stat      (stat_q)
    );

    // programmable registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            scnt_q <= '0;
            sadr_q <= '0;
            sdsc_q <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_CMD:  cmd_q  <= wr_data;
                IDX_SCNT: scnt_q <= wr_data;
                IDX_SADR: sadr_q <= wr_data;
                IDX_SDSC: sdsc_q <= wr_data;
                default:  ;
            endcase
        end
    end

    // working registers
    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q <= '0;
            wadr_q <= WADR_INIT;
            wdsc_q <= WDSC_INIT;
        end else begin
            if (start)              wcnt_q <= scnt_q;
            else if (core_cmd_done) wcnt_q <= '0;
            else if (x_accept)      wcnt_q <= x_next;

            if (start)         wadr_q <= sadr_q;
            else if (x_accept) wadr_q <= wadr_q + xfer_grant;

            if (start) wdsc_q <= sdsc_q;
        end
    end

    assign stat_view = stat_q | (core_irq ? STAT_SINT : '0);

    always_comb begin
        case (rd_idx)
            IDX_CMD:  rd_data = cmd_q;
            IDX_SCNT: rd_data = scnt_q;
            IDX_SADR: rd_data = sadr_q;
            IDX_WCNT: rd_data = wcnt_q;
            IDX_WADR: rd_data = wadr_q;
            IDX_STAT: rd_data = DATA_W'(stat_view);
            IDX_SDSC: rd_data = sdsc_q;
            default:  rd_data = wdsc_q;
        endcase
    end

    assign done_irq = cmd_q[CMD_DONE_IE] && stat_q.done;

    // R4
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (wcnt_q == $past(scnt_q)) && (wadr_q == $past(sadr_q))
                  && (wdsc_q == $past(sdsc_q)) && dma_enable);

    // R6
    step_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (x_accept && !wr_en && !core_cmd_done) |=>
            (wcnt_q == $past(wcnt_q) - $past(xfer_grant))
            && (wadr_q == $past(wadr_q) + $past(xfer_grant)));

    // R6
    grant_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_grant <= wcnt_q) && (xfer_grant <= xfer_len));

    // R5
    wrong_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && xfer_to_mem != cmd_q[CMD_DIR_BIT] && !wr_en && !core_cmd_done)
            |=> $stable(wcnt_q) && $stable(wadr_q));

    // R11
    core_done_chk: assert property (@(posedge clk) disable iff (rst)
        (core_cmd_done && !start) |=> (wcnt_q == '0) && stat_q.done);

    // R9
    wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !stat_wr1c_mode && !rd_en && !xfer_req && !core_cmd_done)
            |=> $stable(stat_q));

    // R10
    irq_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (core_irq && rd_idx == IDX_STAT) |-> rd_data[4]);

endmodule

// File: tb/scsi_dma_regs_bench.sv
module scsi_dma_regs_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 0, rd_en = 0, mode = 0, irq = 0, cdone = 0;
    logic        xreq = 0, xdir = 0;
    logic [2:0]  wr_idx = 0, rd_idx = 0;
    logic [31:0] wr_data = 0, xlen = 0;
    logic [31:0] rd_data, grant;
    logic        dma_en, cancel, dirq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // behavioural model state
    logic [31:0] m_reg [8];
    bit          m_en, m_cancel;

    always #(CLK_PERIOD/2) clk = ~clk;

    scsi_dma_regs u_scsi_dma_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .stat_wr1c_mode(mode), .core_irq(irq), .core_cmd_done(cdone),
        .xfer_req(xreq), .xfer_to_mem(xdir), .xfer_len(xlen),
        .xfer_grant(grant), .dma_enable(dma_en), .cancel_req(cancel),
        .done_irq(dirq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_view(input logic [2:0] i);
        logic [31:0] v = m_reg[i];
        if (i == 3'd5 && irq) v = v | 32'h10;
        return v;
    endfunction

    function automatic logic [31:0] m_grant();
        logic [31:0] c;
        if (!xreq || (xdir != m_reg[0][7])) return 32'h0;
        c = m_reg[3];
        return (xlen < c) ? xlen : c;
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = 32'h0;
        m_reg[4] = 32'hFFFF_FFFF;
        m_reg[7] = 32'hFFFF_FFFD;
        m_en = 0;
        m_cancel = 0;
    endfunction

    function automatic void m_step();
        logic [31:0] g = m_grant();
        m_cancel = 0;
        if (wr_en) begin
            case (wr_idx)
                3'd0: begin
                    m_reg[0] = wr_data;
                    case (wr_data[1:0])
                        2'd0: m_en = 0;
                        2'd2: m_cancel = 1;
                        2'd3: begin
                            m_reg[3] = m_reg[1];
                            m_reg[4] = m_reg[2];
                            m_reg[7] = m_reg[6];
                            m_reg[5] = 0;
                            m_en = 1;
                        end
                        default: ;
                    endcase
                end
                3'd1, 3'd2, 3'd6: m_reg[wr_idx] = wr_data;
                3'd5: if (mode) m_reg[5] = m_reg[5] & ~(wr_data & 32'hE);
                default: ;
            endcase
        end
        if (rd_en && rd_idx == 3'd5 && !mode) m_reg[5] = m_reg[5] & ~32'hE;
        if (xreq && xdir == m_reg[0][7]) begin
            m_reg[3] = m_reg[3] - g;
            m_reg[4] = m_reg[4] + g;
            if (m_reg[3] == 0) m_reg[5] = m_reg[5] | 32'h8;
        end
        if (cdone) begin
            m_reg[3] = 0;
            m_reg[5] = m_reg[5] | 32'h8;
        end
    endfunction

    // compare every output against the model, then clock both
    task automatic cyc(input string tag);
        #1;
        check(tag, rd_data, m_view(rd_idx));
        check(tag, grant, m_grant());
        check(tag, {31'b0, dma_en}, {31'b0, m_en});
        check(tag, {31'b0, cancel}, {31'b0, m_cancel});
        check(tag, {31'b0, dirq}, {31'b0, m_reg[0][6] & m_reg[5][3]});
        @(posedge clk);
        m_step();
        @(negedge clk);
    endtask

    task automatic look(input logic [2:0] i, input string tag);
        rd_idx = i; cyc(tag);
    endtask

    task automatic wr(input logic [2:0] i, input logic [31:0] d, input string tag);
        wr_en = 1; wr_idx = i; wr_data = d; cyc(tag); wr_en = 0;
    endtask

    task automatic rd_clr(input string tag);
        rd_en = 1; rd_idx = 3'd5; cyc(tag); rd_en = 0;
    endtask

    task automatic xfer(input logic d, input logic [31:0] l, input logic [2:0] i, input string tag);
        xreq = 1; xdir = d; xlen = l; rd_idx = i; cyc(tag); xreq = 0;
    endtask

    task automatic cmd_done(input string tag);
        cdone = 1; cyc(tag); cdone = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset values on every index
        for (int i = 0; i < 8; i++) look(3'(i), "R1");

        // R2 writable and read-only registers
        wr(3'd1, 32'h0000_0100, "R2");
        wr(3'd2, 32'h8000_0000, "R2");
        wr(3'd6, 32'h0000_1234, "R2");
        wr(3'd3, 32'hDEAD_BEEF, "R2");
        wr(3'd4, 32'hCAFE_0000, "R2");
        wr(3'd7, 32'h5555_AAAA, "R2");
        for (int i = 0; i < 8; i++) look(3'(i), "R2");

        // R3 R4 start: device to memory, done interrupt enabled
        wr(3'd0, 32'h0000_00C3, "R4");
        look(3'd3, "R4"); look(3'd4, "R4"); look(3'd7, "R4");
        check("R3", {31'b0, dma_en}, 32'h1);

        // R5 wrong direction is refused
        xfer(1'b0, 32'h10, 3'd3, "R5");
        look(3'd3, "R5");
        // R6 partial step
        xfer(1'b1, 32'h40, 3'd3, "R6");
        look(3'd4, "R6");
        check("R6", rd_data, 32'h8000_0040);
        // R7 R12 clipped final step sets done and the interrupt
        xfer(1'b1, 32'h200, 3'd3, "R7");
        look(3'd5, "R7");
        check("R7", rd_data, 32'h8);
        check("R12", {31'b0, dirq}, 32'h1);

        // R10 live interrupt merge
        irq = 1; look(3'd5, "R10");
        check("R10", rd_data, 32'h18);
        irq = 0; look(3'd5, "R10");

        // R8 write-one-to-clear mode
        mode = 1; look(3'd5, "R8");
        rd_clr("R8"); look(3'd5, "R8");
        check("R8", rd_data, 32'h8);
        wr(3'd5, 32'h0000_0008, "R8"); look(3'd5, "R8");
        check("R8", rd_data, 32'h0);

        // R9 clear-on-read mode
        wr(3'd0, 32'h0000_0083, "R9");
        xfer(1'b1, 32'hFFFF_FFFF, 3'd3, "R9");
        mode = 0; look(3'd5, "R9");
        wr(3'd5, 32'h0000_000E, "R9"); look(3'd5, "R9");
        check("R9", rd_data, 32'h8);
        check("R12", {31'b0, dirq}, 32'h0);
        rd_clr("R9"); look(3'd5, "R9");
        check("R9", rd_data, 32'h0);

        // R3 abort pulse, idle, blast
        wr(3'd0, 32'h0000_0002, "R3");
        check("R3", {31'b0, cancel}, 32'h1);
        look(3'd0, "R3");
        check("R3", {31'b0, cancel}, 32'h0);
        wr(3'd0, 32'h0000_0000, "R3");
        check("R3", {31'b0, dma_en}, 32'h0);
        wr(3'd0, 32'h0000_0001, "R3");
        check("R3", {31'b0, dma_en}, 32'h0);

        // R11 completion from the core
        wr(3'd1, 32'h50, "R11");
        wr(3'd0, 32'h0000_0043, "R11");
        cmd_done("R11"); look(3'd3, "R11");
        check("R11", rd_data, 32'h0);
        look(3'd5, "R11");

        // randomized one-action-per-cycle traffic
        for (int n = 0; n < 1500; n++) begin
            int a = $urandom_range(0, 6);
            rd_idx = 3'($urandom);
            case (a)
                0: wr(3'($urandom), $urandom, "R2");
                1: wr(3'd0, {24'h0, 8'($urandom)} | 32'h3, "R4");
                2: rd_clr("R9");
                3: xfer(1'($urandom), $urandom_range(0, 300), 3'($urandom), "R6");
                4: cmd_done("R11");
                5: begin mode = 1'($urandom); irq = 1'($urandom); cyc("R10"); end
                default: wr(3'd1, $urandom_range(0, 1000), "R2");
            endcase
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule